// File: doc/BRIEF.md
# Line-locked horizontal sync generator

This block produces the horizontal sync output of a line-locked video digitizer and reports whether the timing loop is locked. It runs on the double-rate pixel clock. An upstream sync separator supplies a one-cycle strobe for each incoming sync falling edge. A free-running line counter predicts where the next edge should land, and each strobe is judged against a window of 16 pixels (32 clocks) on either side of that prediction. Edges inside the window keep the counter aligned. Runs of such edges acquire lock. Windows that close empty are counted per field to raise an interrupt.

With no video present the counter free-runs and still produces evenly spaced pulses. A lead/lag control value can shorten one pulse in every group of eight, down to nothing. The vertical sync output is passed through only while the loop is acquired and video is present. It stays high otherwise.

Top module: `hsync_lockgen`

## Requirements
- R1: The line period in clocks is chosen by `line_sel_i`: 0 gives 1560, 1 gives 1716, 2 gives 1732, 3 gives 1888, and any other code gives 1920. Successive free-run pulse falling edges are exactly one period apart.
- R2: An accepted sync strobe, sampled at a rising clock edge, puts `hsync_n_o` low from the following cycle for 64 clocks while video is present.
- R3: `locked_o` rises when the eighth consecutive window since alignment closes with an accepted edge inside it. It drops after any window that closes with no edge. It is low whenever video is absent.
- R4: `irq_n_o` goes low once `UNLOCK_LINES` windows (default 128) have closed without lock since the last `field_start_i` pulse. A `field_start_i` pulse returns it high in the next cycle.
- R5: With video absent and `leadlag_i` at or below 49h, all pulses are 64 clocks wide and evenly spaced.
- R6: With video absent and `leadlag_i` above 49h, one pulse in every eight is shortened by `leadlag_i` minus 49h clocks. From 89h upward that pulse is missing entirely. The other seven keep 64 clocks.
- R7: `vsync_n_o` stays high while video is absent or the loop is not acquired. Once the loop is acquired, a `field_start_i` pulse drives it low from the next cycle for three line starts.
- R8: Once acquired, a sync strobe outside the window is ignored. No pulse follows it, the line phase is unchanged and lock is kept.
- R9: While `rst_n` is low, `hsync_n_o`, `vsync_n_o` and `irq_n_o` are high and `locked_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_edge_i | input | 1 | One-cycle strobe per incoming sync falling edge |
| line_sel_i | input | 3 | Line period select |
| video_present_i | input | 1 | High while a video signal is detected |
| leadlag_i | input | 8 | Lead/lag value that shapes the free-run pulse |
| field_start_i | input | 1 | One-cycle strobe at the start of a field's vertical sync |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| locked_o | output | 1 | Most recent window held an accepted edge after acquisition |
| irq_n_o | output | 1 | Active-low unlocked-lines interrupt |
| vsync_n_o | output | 1 | Gated vertical sync, active low |

## Verification
The free-run path is driven with every line-period code, including an unused code, each paired with a different lead/lag value. This covers the unshortened case, the one-clock threshold step, a mid-range shrink and two values past the point where the pulse vanishes. Fall spacing, fall count and total low time over eight lines together separate a wrong period from a wrong width or a missing pulse.

The locked path is tried with four kinds of edge stream. An evenly spaced stream shows acquisition after exactly eight windows. A stray mid-line strobe must neither move the phase nor break lock. A stream that stops shows the lock drop after the first empty window and the interrupt after the unlocked-line limit. Field starts are applied with and without acquisition and with video removed, which separates the gating of the vertical sync from its timing.

// File: rtl/hsg_pkg.sv
package hsg_pkg;

  localparam int unsigned LEN_SQ60  = 1560;
  localparam int unsigned LEN_STD60 = 1716;
  localparam int unsigned LEN_STD50 = 1732;
  localparam int unsigned LEN_SQ50A = 1888;
  localparam int unsigned LEN_SQ50B = 1920;

  localparam int unsigned CNT_W = $clog2(LEN_SQ50B + 1);
  localparam int unsigned SEL_W = 3;

  typedef logic [CNT_W-1:0] cnt_t;

  // Line period in clocks for a select code; unused codes take the longest.
  function automatic cnt_t line_period(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    return cnt_t'(LEN_SQ60);
      3'd1:    return cnt_t'(LEN_STD60);
      3'd2:    return cnt_t'(LEN_STD50);
      3'd3:    return cnt_t'(LEN_SQ50A);
      default: return cnt_t'(LEN_SQ50B);
    endcase
  endfunction

endpackage

// File: rtl/hsg_line_timer.sv
module hsg_line_timer
  import hsg_pkg::*;
#(
  parameter int unsigned WIN_CLKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  cnt_t period_i,
  input  logic sync_edge_i,
  input  logic video_i,
  input  logic acq_i,
  output cnt_t cnt_o,
  output logic close_o,
  output logic hit_o,
  output logic restart_o
);

  localparam cnt_t WIN_C = cnt_t'(WIN_CLKS);

  cnt_t cnt_q, cnt_d;
  logic seen_q, seen_d;
  logic in_win, take, wrap;

  always_comb begin
    in_win    = (cnt_q >= (period_i - WIN_C)) || (cnt_q <= WIN_C);
    // Before acquisition any edge aligns the counter; afterwards only in-window ones.
    take      = video_i && sync_edge_i && (in_win || !acq_i);
    restart_o = take && !in_win;
    wrap      = cnt_q >= (period_i - cnt_t'(1));
    close_o   = (cnt_q == WIN_C) && !take;
    hit_o     = close_o && seen_q;

    if (take)      cnt_d = cnt_t'(1);
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + cnt_t'(1);

    if (take && in_win)          seen_d = 1'b1;
    else if (restart_o || close_o) seen_d = 1'b0;
    else                         seen_d = seen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/hsg_lock_tracker.sv
module hsg_lock_tracker #(
  parameter int unsigned LOCK_RUN     = 8,
  parameter int unsigned UNLOCK_LINES = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic video_i,
  input  logic close_i,
  input  logic hit_i,
  input  logic restart_i,
  input  logic field_start_i,
  output logic acq_o,
  output logic locked_o,
  output logic irq_n_o
);

  localparam int unsigned RUN_W = $clog2(LOCK_RUN + 1);
  localparam int unsigned UNL_W = $clog2(UNLOCK_LINES + 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(LOCK_RUN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);
  localparam logic [UNL_W-1:0] UNL_MAX  = UNL_W'(UNLOCK_LINES);

  logic [RUN_W-1:0] run_q, run_d;
  logic [UNL_W-1:0] unl_q, unl_d;
  logic             acq_q, acq_d;
  logic             last_q, last_d;
  logic             line_unlocked;

  always_comb begin
    run_d  = run_q;
    acq_d  = acq_q;
    last_d = last_q;
    if (!video_i) begin
      run_d  = '0;
      acq_d  = 1'b0;
      last_d = 1'b0;
    end else if (restart_i) begin
      run_d  = '0;
    end else if (close_i) begin
      last_d = hit_i;
      if (!hit_i)                run_d = '0;
      else if (run_q != RUN_MAX) run_d = run_q + RUN_W'(1);
      if (hit_i && (run_q == RUN_LAST)) acq_d = 1'b1;
    end

    line_unlocked = close_i && !(acq_d && hit_i);
    if (field_start_i)                         unl_d = '0;
    else if (line_unlocked && unl_q != UNL_MAX) unl_d = unl_q + UNL_W'(1);
    else                                       unl_d = unl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      acq_q  <= 1'b0;
      last_q <= 1'b0;
      unl_q  <= '0;
    end else begin
      run_q  <= run_d;
      acq_q  <= acq_d;
      last_q <= last_d;
      unl_q  <= unl_d;
    end
  end

  assign acq_o    = acq_q;
  assign locked_o = acq_q && last_q;
  assign irq_n_o  = (unl_q != UNL_MAX);

endmodule

// File: rtl/hsg_pulse_shaper.sv
module hsg_pulse_shaper
  import hsg_pkg::*;
#(
  parameter int unsigned PULSE_W     = 64,
  parameter logic [7:0]  SHRINK_BASE = 8'h49,
  parameter int unsigned GROUP       = 8,
  parameter int unsigned VS_LINES    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cnt_t       cnt_i,
  input  logic       video_i,
  input  logic       acq_i,
  input  logic [7:0] leadlag_i,
  input  logic       field_start_i,
  output logic       hsync_n_o,
  output logic       vsync_n_o
);

  localparam int unsigned W_W   = $clog2(PULSE_W + 1);
  localparam int unsigned GRP_W = $clog2(GROUP);
  localparam int unsigned VSC_W = $clog2(VS_LINES + 1);
  localparam logic [W_W-1:0]   FULL_W   = W_W'(PULSE_W);
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(GROUP - 1);
  localparam logic [VSC_W-1:0] VS_LAST  = VSC_W'(VS_LINES - 1);
  localparam cnt_t             GRP_TICK = cnt_t'(PULSE_W + 1);

  logic [GRP_W-1:0] grp_q, grp_d;
  logic [VSC_W-1:0] vsc_q, vsc_d;
  logic             vs_low_q, vs_low_d;
  logic [7:0]       excess;
  logic [W_W-1:0]   shrink, width;
  logic             hs_active, line_start;

  always_comb begin
    excess = leadlag_i - SHRINK_BASE;
    if (leadlag_i <= SHRINK_BASE)  shrink = '0;
    else if (excess >= 8'(PULSE_W)) shrink = FULL_W;
    else                           shrink = W_W'(excess);

    width     = (!video_i && grp_q == GRP_LAST) ? (FULL_W - shrink) : FULL_W;
    hs_active = (cnt_i != '0) && (cnt_i <= cnt_t'(width));

    grp_d = grp_q;
    if (cnt_i == GRP_TICK) grp_d = (grp_q == GRP_LAST) ? '0 : grp_q + GRP_W'(1);

    line_start = (cnt_i == cnt_t'(1));
    vs_low_d   = vs_low_q;
    vsc_d      = vsc_q;
    if (!video_i || !acq_i) begin
      vs_low_d = 1'b0;
      vsc_d    = '0;
    end else if (field_start_i) begin
      vs_low_d = 1'b1;
      vsc_d    = '0;
    end else if (vs_low_q && line_start) begin
      if (vsc_q == VS_LAST) begin
        vs_low_d = 1'b0;
        vsc_d    = '0;
      end else begin
        vsc_d    = vsc_q + VSC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q    <= '0;
      vsc_q    <= '0;
      vs_low_q <= 1'b0;
    end else begin
      grp_q    <= grp_d;
      vsc_q    <= vsc_d;
      vs_low_q <= vs_low_d;
    end
  end

  assign hsync_n_o = ~hs_active;
  assign vsync_n_o = ~vs_low_q;

endmodule

// File: rtl/hsync_lockgen.sv
module hsync_lockgen
  import hsg_pkg::*;
#(
  parameter int unsigned WIN_PX       = 16,
  parameter int unsigned CLK_PER_PX   = 2,
  parameter int unsigned LOCK_RUN     = 8,
  parameter int unsigned UNLOCK_LINES = 128,
  parameter int unsigned PULSE_W      = 64,
  parameter logic [7:0]  SHRINK_BASE  = 8'h49,
  parameter int unsigned GROUP        = 8,
  parameter int unsigned VS_LINES     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_edge_i,
  input  logic [2:0] line_sel_i,
  input  logic       video_present_i,
  input  logic [7:0] leadlag_i,
  input  logic       field_start_i,
  output logic       hsync_n_o,
  output logic       locked_o,
  output logic       irq_n_o,
  output logic       vsync_n_o
);

  localparam int unsigned WIN_CLKS = WIN_PX * CLK_PER_PX;

  cnt_t period, cnt;
  logic close, hit, restart, acq;

  assign period = line_period(line_sel_i);

  hsg_line_timer #(.WIN_CLKS(WIN_CLKS)) timer_i (
    .clk(clk), .rst_n(rst_n), .period_i(period), .sync_edge_i(sync_edge_i),
    .video_i(video_present_i), .acq_i(acq), .cnt_o(cnt), .close_o(close),
    .hit_o(hit), .restart_o(restart)
  );

  hsg_lock_tracker #(.LOCK_RUN(LOCK_RUN), .UNLOCK_LINES(UNLOCK_LINES)) track_i (
    .clk(clk), .rst_n(rst_n), .video_i(video_present_i), .close_i(close),
    .hit_i(hit), .restart_i(restart), .field_start_i(field_start_i),
    .acq_o(acq), .locked_o(locked_o), .irq_n_o(irq_n_o)
  );

  hsg_pulse_shaper #(
    .PULSE_W(PULSE_W), .SHRINK_BASE(SHRINK_BASE), .GROUP(GROUP), .VS_LINES(VS_LINES)
  ) shape_i (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .video_i(video_present_i), .acq_i(acq),
    .leadlag_i(leadlag_i), .field_start_i(field_start_i),
    .hsync_n_o(hsync_n_o), .vsync_n_o(vsync_n_o)
  );

endmodule

// File: rtl/hsg_checker.sv
module hsg_checker #(
  parameter int unsigned PULSE_W = 64
) (
  input logic clk,
  input logic rst_n,
  input logic video_present_i,
  input logic field_start_i,
  input logic hsync_n_o,
  input logic locked_o,
  input logic irq_n_o,
  input logic vsync_n_o
);

  logic [8:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_run <= '0;
    else if (hsync_n_o)      low_run <= '0;
    else if (low_run != '1)  low_run <= low_run + 9'd1;
  end

  AST_IDLE_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> (hsync_n_o && vsync_n_o && irq_n_o && !locked_o)); // R9

  AST_PULSE_NOT_WIDER: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= 9'(PULSE_W)); // R2

  AST_LOCK_NEEDS_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> $past(video_present_i)); // R3

  AST_FIELD_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    field_start_i |=> irq_n_o); // R4

  AST_VSYNC_IDLE_NO_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
    (!video_present_i && $past(!video_present_i)) |-> (vsync_n_o && !locked_o)); // R7

endmodule

bind hsync_lockgen hsg_checker #(.PULSE_W(PULSE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .video_present_i(video_present_i),
  .field_start_i(field_start_i), .hsync_n_o(hsync_n_o), .locked_o(locked_o),
  .irq_n_o(irq_n_o), .vsync_n_o(vsync_n_o)
);

// File: tb/hsync_lockgen_tb_top.sv
module hsync_lockgen_tb_top;

  localparam int P0  = 1560;
  localparam int WIN = 32;
  localparam int PW  = 64;
  localparam int UNL = 4;
  localparam int NV  = 6;

  // {line_sel[30:28], leadlag[27:20], period[19:8], short pulse width[7:0]}
  localparam logic [30:0] VEC [NV] = '{
    {3'd0, 8'h30, 12'd1560, 8'd64},
    {3'd1, 8'h49, 12'd1716, 8'd64},
    {3'd2, 8'h4A, 12'd1732, 8'd63},
    {3'd3, 8'h69, 12'd1888, 8'd32},
    {3'd4, 8'h89, 12'd1920, 8'd0},
    {3'd7, 8'hFF, 12'd1920, 8'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n, video, fs, stray;
  logic [2:0] line_sel;
  logic [7:0] leadlag;
  logic       hsync_n, locked, irq_n, vsync_n;
  logic       gen_on = 1'b0;
  logic       gen_pulse = 1'b0;
  int         gen_ph = 0;
  int         n_chk = 0;
  int         n_fail = 0;
  logic       sync_edge;

  assign sync_edge = gen_pulse | stray;

  always #2.5 clk = ~clk;

  hsync_lockgen #(.UNLOCK_LINES(UNL)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_edge_i(sync_edge), .line_sel_i(line_sel),
    .video_present_i(video), .leadlag_i(leadlag), .field_start_i(fs),
    .hsync_n_o(hsync_n), .locked_o(locked), .irq_n_o(irq_n), .vsync_n_o(vsync_n)
  );

  // Evenly spaced sync strobes, one per P0 clocks, changed only at falling edges.
  always @(negedge clk) begin
    if (!gen_on) begin
      gen_ph    <= 0;
      gen_pulse <= 1'b0;
    end else begin
      gen_pulse <= (gen_ph == 0);
      gen_ph    <= (gen_ph == P0 - 1) ? 0 : gen_ph + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wait_gen_edge();
    @(posedge clk);
    while (!gen_pulse) @(posedge clk);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b1; video = 1'b0; fs = 1'b0; stray = 1'b0;
    line_sel = 3'd0; leadlag = 8'h00;
    #1 rst_n = 1'b0;
    cycles(3);
    chk("R9 hsync", int'(hsync_n), 1);
    chk("R9 vsync", int'(vsync_n), 1);
    chk("R9 irq", int'(irq_n), 1);
    chk("R9 locked", int'(locked), 0);
    rst_n = 1'b1;

    // Free-run table: R1 spacing, R5/R6 widths and pulse count over eight lines.
    for (int i = 0; i < NV; i++) begin
      int  per, sw, falls, lows, bad;
      logic prev;
      line_sel = VEC[i][30:28];
      leadlag  = VEC[i][27:20];
      per      = int'(VEC[i][19:8]);
      sw       = int'(VEC[i][7:0]);
      do begin
        prev = hsync_n;
        @(negedge clk);
      end while (!(prev && !hsync_n));
      falls = 0; lows = 0; bad = 0; prev = 1'b1;
      for (int t = 0; t < 8 * per; t++) begin
        if (!hsync_n) lows++;
        if (prev && !hsync_n) begin
          falls++;
          if (t % per != 0) bad++;
        end
        prev = hsync_n;
        @(negedge clk);
      end
      chk("R1 off-period falls", bad, 0);
      chk("R6 pulse count", falls, (sw == 0) ? 7 : 8);
      chk((sw == PW) ? "R5 low clocks" : "R6 low clocks", lows, 7 * PW + sw);
    end

    // Acquisition with an evenly spaced edge stream.
    video = 1'b1; line_sel = 3'd0; leadlag = 8'h00;
    do @(negedge clk); while (hsync_n);
    cycles(500);
    gen_on = 1'b1;
    wait_gen_edge();  // out-of-window alignment edge
    for (int k = 1; k <= 8; k++) begin
      wait_gen_edge();
      if (k == 7) begin
        cycles(WIN + 2);
        chk("R3 not yet locked", int'(locked), 0);
      end
      if (k == 8) begin
        cycles(WIN + 2);
        chk("R3 locked after eight", int'(locked), 1);
        chk("R4 irq after unlocked lines", int'(irq_n), 0);
      end
    end

    // Field start while acquired.
    @(negedge clk) fs = 1'b1;
    @(negedge clk) fs = 1'b0;
    chk("R4 field start clears irq", int'(irq_n), 1);
    chk("R7 vsync low", int'(vsync_n), 0);
    cycles(2 * P0 - 2);
    chk("R7 vsync still low", int'(vsync_n), 0);
    cycles(P0 + 10);
    chk("R7 vsync released", int'(vsync_n), 1);

    // Locked pulse width.
    wait_gen_edge();
    @(negedge clk);
    chk("R2 pulse starts", int'(hsync_n), 0);
    cycles(63);
    chk("R2 pulse last clock", int'(hsync_n), 0);
    cycles(1);
    chk("R2 pulse ended", int'(hsync_n), 1);

    // Stray edge in mid-line.
    begin
      int lowseen;
      cycles(700);
      stray = 1'b1;
      @(negedge clk) stray = 1'b0;
      lowseen = 0;
      repeat (80) begin
        if (!hsync_n) lowseen++;
        @(negedge clk);
      end
      chk("R8 no pulse after stray", lowseen, 0);
      wait_gen_edge();
      @(negedge clk);
      chk("R8 pulse at regular phase", int'(hsync_n), 0);
      cycles(WIN + 2);
      chk("R8 lock kept", int'(locked), 1);
    end

    // Edges stop: lock drops, unlocked lines counted.
    wait_gen_edge();
    @(negedge clk);
    fs = 1'b1;
    gen_on = 1'b0;
    @(negedge clk) fs = 1'b0;
    cycles(P0 + 33);
    chk("R3 drop after empty window", int'(locked), 0);
    cycles(2 * P0);
    chk("R4 irq high after three", int'(irq_n), 1);
    cycles(P0);
    chk("R4 irq low after four", int'(irq_n), 0);

    // Video removed: vsync gated high.
    @(negedge clk) fs = 1'b1;
    @(negedge clk) fs = 1'b0;
    chk("R7 vsync low while acquired", int'(vsync_n), 0);
    video = 1'b0;
    cycles(2);
    chk("R7 vsync high without video", int'(vsync_n), 1);
    chk("R3 unlocked without video", int'(locked), 0);

    summary();
  end

endmodule